// File: doc/BRIEF.md
# Timecode Frame Serializer with Selectable Start Event

This block sends one 80-bit linear timecode frame as a biphase-mark serial stream on a single digital line. The frame is presented as a flat 80-bit buffer of ten bytes. A programmable 12-bit divider sets the half-bit period. The divider counts either every system clock or every pulse of a clock enable that runs at twice the receive bit rate. Software loads the buffer, picks a start event, and raises the transmit enable. The block then waits for that event and emits a complete frame. In free-run mode it chains frames back to back.

There are four possible start events. One is the start of video line 5, given as a synchronous pulse. One is a rising edge on an asynchronous click input. One is a rising edge on the asynchronous receive sync-detect input. The last is a synchronous software strobe. The two asynchronous inputs pass through a synchronizer and an edge detector in the system clock domain. The enable is only acted on at frame boundaries, so a frame that has started is always completed. A one-cycle done strobe marks the end of every frame.

The control is a three-state machine, with states ST_IDLE, ST_ARMED and ST_SEND:
- ST_IDLE goes to ST_ARMED on "enable seen".
- ST_ARMED goes back to ST_IDLE on "enable lost".
- ST_ARMED goes to ST_SEND on "start event".
- ST_SEND goes to ST_ARMED on "frame end, enabled, not free-run".
- ST_SEND stays in ST_SEND on "frame end, enabled, free-run" (chain).
- ST_SEND goes to ST_IDLE on "frame end, disabled".
- In every other cycle, ST_SEND holds.

Top module: `tcode_tx`

## Requirements
- R1: While reset is held and in the first cycle after it, the serial line is low and the done strobe is low.
- R2: One half-bit lasts (D+1) divider input counts. D is {div_hi[3:0], div_lo}, and bits 7:4 of div_hi have no effect.
- R3: With div_src = 0 the divider counts every system clock. With div_src = 1 it counts only the cycles in which rx_clk_en is high.
- R4: The line toggles at the start of every bit. It toggles again at mid-bit only for a 1 bit, so bit value = (level in first half) XOR (level in second half).
- R5: Bit i of frame_buf is sent as the i-th bit. That means byte 0 (bits 7:0) goes first, least significant bit first. The buffer is captured at frame start, so later changes do not affect the frame in flight.
- R6: sync_sel picks the start event: 00 = line5_pulse, 01 = rising click_in, 10 = rising rx_sync_det, 11 = sw_strobe. A synchronous event starts the frame on the edge where it is high. An asynchronous input that is high by one edge starts the frame two edges later.
- R7: With free_run = 0, after each frame the block waits for a new start event, and the line stays constant while it waits.
- R8: With free_run = 1, the next frame starts on the same edge the previous one ends, giving a frame period of 160*(D+1) counts. The first frame after enabling still waits for a start event.
- R9: tx_en is sampled only while no frame is in progress and at frame end. Clearing it mid-frame lets that frame complete, after which no further frames are sent.
- R10: A start event that arrives during a frame is ignored.
- R11: frame_done is high for exactly one cycle, beginning 160*(D+1) counts after the frame-start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the internal divider reference |
| rst_n | input | 1 | Active-low reset |
| div_lo | input | 8 | Divider value, low byte |
| div_hi | input | 8 | Divider value, high byte (bits 3:0 used) |
| div_src | input | 1 | Divider input: 0 system clock, 1 receive clock enable |
| rx_clk_en | input | 1 | Pulse per doubled receive clock period |
| sync_sel | input | 2 | Start-event select |
| free_run | input | 1 | Chain frames back to back |
| tx_en | input | 1 | Transmit enable |
| line5_pulse | input | 1 | Synchronous start-of-line-5 pulse |
| click_in | input | 1 | Asynchronous click input |
| rx_sync_det | input | 1 | Asynchronous receive sync-pattern detect |
| sw_strobe | input | 1 | Synchronous software start strobe |
| frame_buf | input | 80 | Frame data, bit i sent i-th |
| tx_out | output | 1 | Biphase-mark serial output |
| frame_done | output | 1 | One-cycle end-of-frame strobe |

## Verification
The first toggle of a frame appears on the edge that takes the start event. For synchronous events that is the same edge on which the event is high. For the click and receive-detect inputs it is two edges after the one that first samples the input. From there, each further half-bit level is due exactly (D+1) counts later, and frame_done is due 160*(D+1) counts after the start edge. The bench therefore samples the line at the falling clock edge that follows each of these computed rising edges. It measures frame periods by counting falling edges between done strobes, which makes the divider and source checks independent of the phase of the receive clock enable.

// File: rtl/tcode_pkg.sv
package tcode_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_SEND  = 2'd2
    } tx_state_e;

    typedef enum logic [1:0] {
        SYN_LINE5 = 2'b00,
        SYN_CLICK = 2'b01,
        SYN_RXDET = 2'b10,
        SYN_SOFT  = 2'b11
    } sync_src_e;
endpackage

// File: rtl/tcode_tick_gen.sv
module tcode_tick_gen #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             src_sel,
    input  logic             rx_clk_en,
    input  logic [DIV_W-1:0] div_val,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic             step;

    // one count per system clock or per receive clock enable
    assign step = src_sel ? rx_clk_en : 1'b1;
    // >= keeps the period bounded if the divider is lowered mid-count
    assign tick = step && (cnt >= div_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= tick ? '0 : cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/tcode_sync_sel.sv
module tcode_sync_sel
    import tcode_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sel,
    input  logic       line5_pulse,
    input  logic       click_in,
    input  logic       rx_sync_det,
    input  logic       sw_strobe,
    output logic       sync_evt
);
    localparam int N_ASYNC = 2;

    logic [N_ASYNC-1:0] async_in;
    logic [N_ASYNC-1:0] rise;

    assign async_in = {rx_sync_det, click_in};

    generate
        for (genvar g = 0; g < N_ASYNC; g++) begin : g_sync
            // STAGES synchronizer flops plus one history flop
            logic [STAGES:0] sh;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh <= '0;
                else        sh <= {sh[STAGES-1:0], async_in[g]};
            end
            assign rise[g] = sh[STAGES-1] & ~sh[STAGES];
        end
    endgenerate

    always_comb begin
        unique case (sync_src_e'(sel))
            SYN_LINE5: sync_evt = line5_pulse;
            SYN_CLICK: sync_evt = rise[0];
            SYN_RXDET: sync_evt = rise[1];
            SYN_SOFT:  sync_evt = sw_strobe;
            default:   sync_evt = 1'b0;
        endcase
    end
endmodule

// File: rtl/tcode_tx.sv
module tcode_tx
    import tcode_pkg::*;
#(
    parameter int DIV_W       = 12,
    parameter int BYTE_W      = 8,
    parameter int FRAME_BYTES = 10,
    parameter int SYNC_STAGES = 2,
    localparam int FRAME_BITS = FRAME_BYTES * BYTE_W,
    localparam int IDX_W      = $clog2(FRAME_BITS),
    localparam int HI_USED    = DIV_W - BYTE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [BYTE_W-1:0]     div_lo,
    input  logic [BYTE_W-1:0]     div_hi,
    input  logic                  div_src,
    input  logic                  rx_clk_en,
    input  logic [1:0]            sync_sel,
    input  logic                  free_run,
    input  logic                  tx_en,
    input  logic                  line5_pulse,
    input  logic                  click_in,
    input  logic                  rx_sync_det,
    input  logic                  sw_strobe,
    input  logic [FRAME_BITS-1:0] frame_buf,
    output logic                  tx_out,
    output logic                  frame_done
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

    tx_state_e state, state_nx;

    logic [DIV_W-1:0]      div_val;
    logic                  unused_hi_bits;
    logic                  tick;
    logic                  sync_evt;
    logic                  start_frame;
    logic                  frame_end;
    logic                  busy;
    logic                  is_idle;
    logic                  half;
    logic [IDX_W-1:0]      bit_idx;
    logic [FRAME_BITS-1:0] shreg;

    assign div_val        = {div_hi[HI_USED-1:0], div_lo};
    assign unused_hi_bits = ^div_hi[BYTE_W-1:HI_USED];

    tcode_tick_gen #(.DIV_W(DIV_W)) tick_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (start_frame),
        .src_sel   (div_src),
        .rx_clk_en (rx_clk_en),
        .div_val   (div_val),
        .tick      (tick)
    );

    tcode_sync_sel #(.STAGES(SYNC_STAGES)) sync_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (sync_sel),
        .line5_pulse (line5_pulse),
        .click_in    (click_in),
        .rx_sync_det (rx_sync_det),
        .sw_strobe   (sw_strobe),
        .sync_evt    (sync_evt)
    );

    assign busy      = (state == ST_SEND);
    assign is_idle   = (state == ST_IDLE);
    assign frame_end = busy && tick && half && (bit_idx == LAST_IDX);
    assign start_frame = ((state == ST_ARMED) && tx_en && sync_evt)
                       || (frame_end && tx_en && free_run);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (tx_en) state_nx = ST_ARMED;              // enable seen
            end
            ST_ARMED: begin
                if (!tx_en)        state_nx = ST_IDLE;       // enable lost
                else if (sync_evt) state_nx = ST_SEND;       // start event
            end
            ST_SEND: begin
                if (frame_end) begin
                    if (!tx_en)        state_nx = ST_IDLE;   // frame end, disabled
                    else if (free_run) state_nx = ST_SEND;   // chain
                    else               state_nx = ST_ARMED;  // frame end, re-arm
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // serializer and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg      <= '0;
            bit_idx    <= '0;
            half       <= 1'b0;
            tx_out     <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= frame_end;
            if (start_frame) begin
                shreg   <= frame_buf;
                bit_idx <= '0;
                half    <= 1'b0;
                tx_out  <= ~tx_out;
            end else if (busy && tick) begin
                if (!half) begin
                    half <= 1'b1;
                    if (shreg[0]) tx_out <= ~tx_out;
                end else begin
                    half <= 1'b0;
                    if (bit_idx != LAST_IDX) begin
                        bit_idx <= bit_idx + IDX_W'(1);
                        shreg   <= shreg >> 1;
                        tx_out  <= ~tx_out;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/tcode_tx_chk.sv
module tcode_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic is_idle,
    input logic tick,
    input logic start_frame,
    input logic frame_end,
    input logic tx_out,
    input logic frame_done
);
    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R11
    done_after_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(busy));

    // R7
    tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> $stable(tx_out));

    // R4
    edge_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick && !start_frame) |=> $stable(tx_out));

    // R9
    no_direct_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_idle |=> !busy);

    // R10
    send_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !frame_end) |=> busy);
endmodule

bind tcode_tx tcode_tx_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .is_idle     (is_idle),
    .tick        (tick),
    .start_frame (start_frame),
    .frame_end   (frame_end),
    .tx_out      (tx_out),
    .frame_done  (frame_done)
);

// File: tb/tcode_tx_tb.sv
`timescale 1ns/1ps
module tcode_tx_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  div_lo = 8'd0;
    logic [7:0]  div_hi = 8'd0;
    logic        div_src = 1'b0;
    logic        rx_clk_en = 1'b0;
    logic [1:0]  sync_sel = 2'b11;
    logic        free_run = 1'b0;
    logic        tx_en = 1'b0;
    logic        line5_pulse = 1'b0;
    logic        click_in = 1'b0;
    logic        rx_sync_det = 1'b0;
    logic        sw_strobe = 1'b0;
    logic [79:0] frame_buf = '0;
    logic        tx_out;
    logic        frame_done;

    int checks = 0;
    int errors = 0;
    int rx_ph = 0;

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        rx_clk_en <= (rx_ph == 2);
        rx_ph = (rx_ph == 2) ? 0 : rx_ph + 1;
    end

    tcode_tx dut_i (
        .clk(clk), .rst_n(rst_n), .div_lo(div_lo), .div_hi(div_hi),
        .div_src(div_src), .rx_clk_en(rx_clk_en), .sync_sel(sync_sel),
        .free_run(free_run), .tx_en(tx_en), .line5_pulse(line5_pulse),
        .click_in(click_in), .rx_sync_det(rx_sync_det), .sw_strobe(sw_strobe),
        .frame_buf(frame_buf), .tx_out(tx_out), .frame_done(frame_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int sync_latency(input logic [1:0] sel);
        return (sel == 2'b01 || sel == 2'b10) ? 3 : 1;
    endfunction

    // pulse the selected start event from a falling edge; returns at the
    // falling edge just after the start edge, with the level before it
    task automatic fire_event(input logic [1:0] sel, output logic prev);
        @(negedge clk);
        prev = tx_out;
        case (sel)
            2'b00: line5_pulse = 1'b1;
            2'b01: click_in = 1'b1;
            2'b10: rx_sync_det = 1'b1;
            default: sw_strobe = 1'b1;
        endcase
        repeat (sync_latency(sel)) @(posedge clk);
        @(negedge clk);
        line5_pulse = 1'b0;
        sw_strobe = 1'b0;
    endtask

    task automatic wait_done(output int n, input int limit);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!frame_done && n < limit);
    endtask

    // one complete non-free-run frame with internal clock, checked half by half
    task automatic run_frame(input int d, input logic [1:0] sel, input logic [79:0] data);
        logic lvl [160];
        logic prev;
        logic [79:0] got;
        int bad_edges;
        bit early;
        div_lo = 8'(d);
        div_hi = 8'hF0;          // upper nibble must not matter (R2)
        div_src = 1'b0;
        free_run = 1'b0;
        sync_sel = sel;
        frame_buf = data;
        tx_en = 1'b1;
        repeat (3) @(posedge clk);
        fire_event(sel, prev);
        lvl[0] = tx_out;
        early = 1'b0;
        for (int h = 1; h < 160; h++) begin
            repeat (d + 1) @(posedge clk);
            @(negedge clk);
            if (h == 1)  frame_buf = ~data;   // captured already (R5)
            if (h == 20) begin click_in = 1'b0; rx_sync_det = 1'b0; end
            if (h == 40) begin               // stray events mid-frame (R10)
                sw_strobe = 1'b1; line5_pulse = 1'b1;
                click_in = 1'b1; rx_sync_det = 1'b1;
            end
            if (h == 41) begin sw_strobe = 1'b0; line5_pulse = 1'b0; end
            lvl[h] = tx_out;
            if (frame_done) early = 1'b1;
        end
        repeat (d + 1) @(posedge clk);
        @(negedge clk);
        check(frame_done === 1'b1 && !early, "R11", "done timing",
              {78'd0, early, frame_done}, 80'd1);
        click_in = 1'b0;
        rx_sync_det = 1'b0;
        bad_edges = 0;
        for (int b = 0; b < 80; b++) begin
            if (lvl[2*b] == ((b == 0) ? prev : lvl[2*b-1])) bad_edges++;
            got[b] = lvl[2*b] ^ lvl[2*b+1];
        end
        check(bad_edges == 0, "R4", "missing bit-start toggles", 80'(bad_edges), 80'd0);
        check(got == data, "R5/R6/R10", "decoded frame", got, data);
        @(negedge clk);
        check(frame_done === 1'b0, "R11", "done width", {79'd0, frame_done}, 80'd0);
    endtask

    task automatic quiet_check(input int n, input string req);
        logic l0;
        bit moved;
        l0 = tx_out;
        moved = 1'b0;
        repeat (n) begin
            @(negedge clk);
            if (tx_out !== l0 || frame_done) moved = 1'b1;
        end
        check(!moved, req, "line idle while waiting", {79'd0, moved}, 80'd0);
    endtask

    task automatic stop_tx();
        int n;
        tx_en = 1'b0;
        wait_done(n, 50000);
        repeat (4) @(negedge clk);
    endtask

    // free-run period measurement for a given divider setup
    task automatic measure_period(input logic [7:0] hi, input logic [7:0] lo,
                                  input logic src, input int exp, input string req);
        logic prev;
        int n;
        div_hi = hi; div_lo = lo; div_src = src;
        free_run = 1'b1; sync_sel = 2'b11; tx_en = 1'b1;
        repeat (3) @(posedge clk);
        fire_event(2'b11, prev);
        wait_done(n, 50000);
        wait_done(n, 50000);
        check(n == exp, req, "frame period", 80'(n), 80'(exp));
        stop_tx();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic prev;
        int n;
        void'($urandom(32'h7c0de5));
        repeat (3) @(negedge clk);
        check(tx_out === 1'b0 && frame_done === 1'b0, "R1", "in reset",
              {78'd0, tx_out, frame_done}, 80'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_out === 1'b0 && frame_done === 1'b0, "R1", "after reset",
              {78'd0, tx_out, frame_done}, 80'd0);

        // directed frames: each start source, alternating bit patterns
        run_frame(0, 2'b11, 80'hAAAA_5555_FF00_0F0F_1234);
        run_frame(1, 2'b00, 80'h0000_0000_0000_0000_0001);
        run_frame(0, 2'b01, 80'hFFFF_FFFF_FFFF_FFFF_FFFF);
        run_frame(2, 2'b10, 80'h8000_0000_0000_0000_0000);

        // R7: no sync, no free-run -> nothing leaves
        quiet_check(60, "R7");

        // constrained random frames
        for (int i = 0; i < 5; i++) begin
            logic [95:0] r;
            r = {$urandom, $urandom, $urandom};
            run_frame(int'($urandom % 4), 2'($urandom), r[79:0]);
        end

        stop_tx();
        // R8: free-run enabled, but first frame still needs an event
        div_hi = 8'h00; div_lo = 8'd1; div_src = 1'b0;
        free_run = 1'b1; sync_sel = 2'b11; tx_en = 1'b1;
        quiet_check(100, "R8");
        fire_event(2'b11, prev);
        wait_done(n, 50000);
        check(n == 320, "R8", "first frame length", 80'(n), 80'd320);
        wait_done(n, 50000);
        check(n == 320, "R8", "chained frame period", 80'(n), 80'd320);

        // R9: drop enable mid-frame, frame completes, then silence
        repeat (100) @(negedge clk);
        tx_en = 1'b0;
        wait_done(n, 50000);
        check(n == 220, "R9", "frame finished after disable", 80'(n), 80'd220);
        quiet_check(700, "R9");
        // R9: re-enabling alone starts nothing
        tx_en = 1'b1;
        quiet_check(100, "R9");
        tx_en = 1'b0;
        repeat (3) @(negedge clk);

        // R2: upper nibble ignored, full 12-bit value used
        measure_period(8'hF0, 8'd2, 1'b0, 480, "R2");
        measure_period(8'hF1, 8'h01, 1'b0, 160 * 258, "R2");
        // R3: receive clock enable source, one pulse per 3 cycles
        measure_period(8'h00, 8'd1, 1'b1, 160 * 2 * 3, "R3");
        measure_period(8'h50, 8'd0, 1'b1, 160 * 1 * 3, "R3");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule